// File: doc/BRIEF.md
# Bit-Serial Add Core

This block is a compact integer core that runs only the two 32-bit addition forms of RV32I: register plus sign-extended 12-bit immediate, and register plus register. Each instruction begins with a single-cycle fetch. In that cycle the core presents its program counter on an instruction bus together with a valid flag. It then waits until the instruction word is returned under its own valid flag. After one decode cycle it runs the addition one bit position per clock, least significant bit first. A one-bit adder keeps the carry in a flip-flop from one clock to the next.

The register file is a set of 32-bit shift registers. While an addition runs, the source registers rotate one place per clock, so their lowest bit is always the next operand bit. The destination register shifts right by one place per clock and takes the new result bit at its top. After 32 clocks the destination holds the full sum and the sources are back in their original state. The core then adds 4 to the program counter and fetches again. A read port for observation returns any register in the same cycle it is selected. Instruction words of any other form are fetched and skipped without effect.

Top module: `serial_add_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the program counter is 0 and `ibus_addr_vld` is high. The valid flag stays high for exactly one cycle per instruction. Each fetch presents an address 4 higher than the fetch before it.
- R2: After a fetch the core waits for as many cycles as needed and samples `ibus_inst` in the first cycle that `ibus_inst_vld` is high. A valid pulse that arrives while an instruction is decoding or executing is ignored.
- R3: A word with bits [6:0] = 0010011 and bits [14:12] = 000 writes rs1 (bits [19:15]) plus the immediate (bits [31:20]) into rd (bits [11:7]), modulo 2^32.
- R4: A word with bits [6:0] = 0110011, bits [14:12] = 000 and bits [31:25] = 0000000 writes rs1 plus rs2 (bits [24:20]) into rd, modulo 2^32.
- R5: The carry passes across all 32 bit positions, so 0xFFFFFFFF + 1 gives 0. The carry is cleared before bit 0 of every instruction, so a carry left over from the previous addition never enters the next one.
- R6: The immediate is sign-extended from bit 11. For example, -1 adds 0xFFFFFFFF and -2048 gives 0xFFFFF800 when added to zero.
- R7: Register 0 always reads as zero. A result whose destination is register 0 is discarded.
- R8: A destination equal to one or both source registers gives the sum of the values those registers held before the instruction.
- R9: For a recognised addition, the next fetch comes exactly 34 cycles after the cycle in which the instruction word was accepted. The 34 cycles are one decode cycle, then 32 bit cycles, counting the acceptance cycle's edge. For any other word, the next fetch comes 2 cycles after acceptance.
- R10: An instruction word of any other form, including encodings that differ from an addition only in bits [31:25], changes no register and advances the program counter by 4.
- R11: `dbg_data` shows the register selected by `dbg_sel` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ibus_addr | output | 32 | Program counter presented during fetch |
| ibus_addr_vld | output | 1 | High in the single fetch cycle |
| ibus_inst | input | 32 | Returned instruction word |
| ibus_inst_vld | input | 1 | Qualifies `ibus_inst` |
| dbg_sel | input | 5 | Register index for the observation port |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The hardest case to create from the ports is a leftover carry. Its effect shows only when an addition that overflows out of bit 31 is followed at once by one whose true result needs no carry into bit 0. The stimulus therefore places 0xFFFFFFFF + 1 directly before 1 + 1 and expects 2, not 3. A second hard case is a register that is both source and destination while its bits are being rotated and replaced in the same clocks. It is reached with an instruction that doubles a register in place, and with one whose destination equals its first source. Stray instruction-valid pulses are injected in the middle of an addition, and their ignored word is checked afterwards through the observation port.

// File: rtl/sac_pkg.sv
package sac_pkg;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_DECODE = 2'd2,
        ST_EXEC   = 2'd3
    } seq_state_e;

    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [6:0] F7_ADD  = 7'b0000000;

    typedef struct packed {
        logic        ok;
        logic        use_imm;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [11:0] imm;
    } dec_t;

endpackage

// File: rtl/sac_decode.sv
module sac_decode
    import sac_pkg::*;
(
    input  logic [31:0] inst,
    output dec_t        dec
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       is_imm;
    logic       is_reg;

    always_comb begin
        opc    = inst[6:0];
        f3     = inst[14:12];
        f7     = inst[31:25];
        is_imm = (opc == OPC_IMM) && (f3 == F3_ADD);
        is_reg = (opc == OPC_REG) && (f3 == F3_ADD) && (f7 == F7_ADD);

        dec.ok      = is_imm || is_reg;
        dec.use_imm = is_imm;
        dec.rd      = inst[11:7];
        dec.rs1     = inst[19:15];
        dec.rs2     = inst[24:20];
        dec.imm     = inst[31:20];
    end
endmodule

// File: rtl/sac_seq.sv
module sac_seq
    import sac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int PC_STEP = 4,
    localparam int CNT_W = $clog2(XLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  inst_in,
    input  logic             inst_vld,
    input  logic             dec_ok,
    output logic [XLEN-1:0]  pc,
    output logic             fetch,
    output logic [XLEN-1:0]  inst_q,
    output logic             carry_clr,
    output logic             exec_en,
    output logic [CNT_W-1:0] bit_idx
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(XLEN - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  inst;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d;
    seq_t s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_FETCH: begin
                s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (inst_vld) begin
                    s_d.inst = inst_in;
                    s_d.st   = ST_DECODE;
                end
            end
            ST_DECODE: begin
                s_d.cnt = '0;
                if (dec_ok) begin
                    s_d.st = ST_EXEC;
                end else begin
                    s_d.pc = s_q.pc + XLEN'(PC_STEP);
                    s_d.st = ST_FETCH;
                end
            end
            ST_EXEC: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == LAST_BIT) begin
                    s_d.cnt = '0;
                    s_d.pc  = s_q.pc + XLEN'(PC_STEP);
                    s_d.st  = ST_FETCH;
                end
            end
            default: s_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_FETCH;
            s_q.pc   <= '0;
            s_q.inst <= '0;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc        = s_q.pc;
    assign fetch     = (s_q.st == ST_FETCH);
    assign inst_q    = s_q.inst;
    assign carry_clr = (s_q.st == ST_DECODE);
    assign exec_en   = (s_q.st == ST_EXEC);
    assign bit_idx   = s_q.cnt;
endmodule

// File: rtl/sac_bit_alu.sv
module sac_bit_alu (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic a,
    input  logic b,
    output logic sum,
    output logic carry
);
    typedef struct packed {
        logic c;
    } alu_t;

    alu_t a_d;
    alu_t a_q;

    always_comb begin
        a_d = a_q;
        sum = a ^ b ^ a_q.c;
        if (clr) begin
            a_d.c = 1'b0;
        end else if (en) begin
            a_d.c = (a & b) | (a & a_q.c) | (b & a_q.c);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q.c <= 1'b0;
        end else begin
            a_q <= a_d;
        end
    end

    assign carry = a_q.c;
endmodule

// File: rtl/sac_regfile.sv
module sac_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic [AW-1:0]   rs1,
    input  logic [AW-1:0]   rs2,
    input  logic [AW-1:0]   rd,
    input  logic            wbit,
    output logic            rs1_bit,
    output logic            rs2_bit,
    input  logic [AW-1:0]   rsel,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] r_d [NREG];
    logic [XLEN-1:0] r_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            r_d[i] = r_q[i];
            if (shift_en && (i != 0)) begin
                if (AW'(i) == rd) begin
                    r_d[i] = {wbit, r_q[i][XLEN-1:1]};
                end else if ((AW'(i) == rs1) || (AW'(i) == rs2)) begin
                    r_d[i] = {r_q[i][0], r_q[i][XLEN-1:1]};
                end
            end
        end
        r_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                r_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                r_q[i] <= r_d[i];
            end
        end
    end

    assign rs1_bit = r_q[rs1][0];
    assign rs2_bit = r_q[rs2][0];
    assign rdata   = r_q[rsel];
endmodule

// File: rtl/serial_add_core.sv
module serial_add_core
    import sac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int IMM_W = 12,
    localparam int AW    = $clog2(NREG),
    localparam int CNT_W = $clog2(XLEN + 1),
    localparam int IMM_IW = $clog2(IMM_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] ibus_addr,
    output logic            ibus_addr_vld,
    input  logic [XLEN-1:0] ibus_inst,
    input  logic            ibus_inst_vld,
    input  logic [AW-1:0]   dbg_sel,
    output logic [XLEN-1:0] dbg_data
);
    logic [XLEN-1:0]  inst_q;
    logic             carry_clr;
    logic             exec_en;
    logic [CNT_W-1:0] bit_idx;
    dec_t             dec;
    logic             rs1_bit;
    logic             rs2_bit;
    logic             imm_bit;
    logic             opb_bit;
    logic             sum_bit;
    logic             carry_q;

    sac_seq #(.XLEN(XLEN)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .inst_in   (ibus_inst),
        .inst_vld  (ibus_inst_vld),
        .dec_ok    (dec.ok),
        .pc        (ibus_addr),
        .fetch     (ibus_addr_vld),
        .inst_q    (inst_q),
        .carry_clr (carry_clr),
        .exec_en   (exec_en),
        .bit_idx   (bit_idx)
    );

    sac_decode i_dec (
        .inst (inst_q),
        .dec  (dec)
    );

    // Serial immediate: positions above the top field bit repeat the sign bit.
    always_comb begin
        if (bit_idx < CNT_W'(IMM_W)) begin
            imm_bit = dec.imm[bit_idx[IMM_IW-1:0]];
        end else begin
            imm_bit = dec.imm[IMM_W-1];
        end
        opb_bit = dec.use_imm ? imm_bit : rs2_bit;
    end

    sac_bit_alu i_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (carry_clr),
        .en    (exec_en),
        .a     (rs1_bit),
        .b     (opb_bit),
        .sum   (sum_bit),
        .carry (carry_q)
    );

    sac_regfile #(.XLEN(XLEN), .NREG(NREG)) i_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (exec_en),
        .rs1      (dec.rs1[AW-1:0]),
        .rs2      (dec.rs2[AW-1:0]),
        .rd       (dec.rd[AW-1:0]),
        .wbit     (sum_bit),
        .rs1_bit  (rs1_bit),
        .rs2_bit  (rs2_bit),
        .rsel     (dbg_sel),
        .rdata    (dbg_data)
    );
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] addr,
    input logic            addr_vld,
    input logic [AW-1:0]   sel,
    input logic [XLEN-1:0] data,
    input logic            exec_en,
    input logic            carry_q
);
    logic [XLEN-1:0] last_pc_q;
    logic            seen_q;
    logic [7:0]      run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pc_q <= '0;
            seen_q    <= 1'b0;
            run_q     <= '0;
        end else begin
            if (addr_vld) begin
                last_pc_q <= addr;
                seen_q    <= 1'b1;
            end
            run_q <= exec_en ? run_q + 8'd1 : 8'd0;
        end
    end

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) addr_vld |=> !addr_vld); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (addr_vld && seen_q) |-> (addr == last_pc_q + XLEN'(4))); // R1
    AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (sel == '0) |-> (data == '0)); // R7
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(exec_en) |-> !carry_q); // R5
    AST_NO_FETCH_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n) exec_en |-> !addr_vld); // R9
    AST_EXEC_LEN: assert property (@(posedge clk) disable iff (!rst_n) (run_q != '0 && !exec_en) |-> (run_q == 8'(XLEN))); // R9
endmodule

bind serial_add_core sac_checker #(.XLEN(XLEN), .AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (ibus_addr),
    .addr_vld (ibus_addr_vld),
    .sel      (dbg_sel),
    .data     (dbg_data),
    .exec_en  (exec_en),
    .carry_q  (carry_q)
);

// File: tb/test_serial_add_core.sv
module test_serial_add_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ibus_addr;
    logic        ibus_addr_vld;
    logic [31:0] ibus_inst;
    logic        ibus_inst_vld;
    logic [4:0]  dbg_sel;
    logic [31:0] dbg_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic [31:0] exp_pc;

    always #10 clk = ~clk;

    serial_add_core i_serial_add_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .ibus_addr     (ibus_addr),
        .ibus_addr_vld (ibus_addr_vld),
        .ibus_inst     (ibus_inst),
        .ibus_inst_vld (ibus_inst_vld),
        .dbg_sel       (dbg_sel),
        .dbg_data      (dbg_data)
    );

    function automatic logic [31:0] enc_addi(input int rd, input int rs1, input int imm);
        logic [11:0] i12 = 12'(imm);
        return {i12, 5'(rs1), 3'b000, 5'(rd), 7'b0010011};
    endfunction

    function automatic logic [31:0] enc_add(input int rd, input int rs1, input int rs2);
        return {7'b0000000, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_sub(input int rd, input int rs1, input int rs2);
        return {7'b0100000, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
    endfunction

    // {instruction, register to read back, expected value, expected latency}
    localparam int NV = 16;
    localparam logic [76:0] VEC [NV] = '{
        {enc_addi(1, 0, 1946),  5'd1,  32'd1946,       8'd34},  // R3
        {enc_addi(2, 1, 25),    5'd2,  32'd1971,       8'd34},  // R3
        {enc_addi(3, 0, 53),    5'd3,  32'd53,         8'd34},  // R3
        {enc_add(4, 2, 3),      5'd4,  32'd2024,       8'd34},  // R4
        {enc_addi(5, 0, -1),    5'd5,  32'hFFFF_FFFF,  8'd34},  // R6
        {enc_addi(6, 0, 1),     5'd6,  32'd1,          8'd34},  // R3
        {enc_add(7, 5, 6),      5'd7,  32'd0,          8'd34},  // R5 carry chain
        {enc_add(8, 6, 6),      5'd8,  32'd2,          8'd34},  // R5 carry cleared
        {enc_add(4, 4, 4),      5'd4,  32'd4048,       8'd34},  // R8
        {enc_addi(9, 0, -2048), 5'd9,  32'hFFFF_F800,  8'd34},  // R6
        {enc_addi(0, 1, 5),     5'd0,  32'd0,          8'd34},  // R7
        {enc_add(10, 0, 3),     5'd10, 32'd53,         8'd34},  // R7
        {enc_sub(3, 2, 3),      5'd3,  32'd53,         8'd2},   // R10
        {32'hABCDE1B7,          5'd3,  32'd53,         8'd2},   // R10
        {enc_add(3, 3, 2),      5'd3,  32'd2024,       8'd34},  // R8
        {enc_addi(11, 5, 2047), 5'd11, 32'd2046,       8'd34}   // R3 R6
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic read_reg(input int r, output logic [31:0] v);
        dbg_sel = 5'(r);
        #1;
        v = dbg_data;
    endtask

    // Serves one fetch; returns cycles from acceptance to the next fetch.
    task automatic run_inst(input logic [31:0] ins, input int dly, input int pulse_at,
                            input logic [31:0] junk, output int lat);
        int guard = 0;
        while (!ibus_addr_vld && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(ibus_addr == exp_pc, "R1 fetch address", ibus_addr, exp_pc);
        exp_pc = exp_pc + 32'd4;
        @(negedge clk);
        chk(!ibus_addr_vld, "R1 single fetch cycle", 32'(ibus_addr_vld), 32'd0);
        repeat (dly) @(negedge clk);
        ibus_inst     = ins;
        ibus_inst_vld = 1'b1;
        @(negedge clk);
        ibus_inst_vld = 1'b0;
        ibus_inst     = '0;
        lat = 1;
        while (!ibus_addr_vld && lat < 100) begin
            if (lat == pulse_at) begin
                ibus_inst     = junk;
                ibus_inst_vld = 1'b1;
            end
            @(negedge clk);
            ibus_inst_vld = 1'b0;
            lat++;
        end
    endtask

    initial begin
        logic [31:0] v;
        int lat;
        rst_n         = 1'b0;
        ibus_inst     = '0;
        ibus_inst_vld = 1'b0;
        dbg_sel       = '0;
        exp_pc        = '0;
        repeat (3) @(negedge clk);
        chk(ibus_addr_vld && ibus_addr == 0, "R1 reset state", ibus_addr, 32'd0);
        rst_n = 1'b1;
        #1;
        chk(ibus_addr_vld && ibus_addr == 0, "R1 first cycle after reset", ibus_addr, 32'd0);

        for (int k = 0; k < NV; k++) begin
            run_inst(VEC[k][76:45], k % 3, 0, '0, lat);
            chk(lat == int'(VEC[k][7:0]), "R9 next fetch latency", 32'(lat), 32'(VEC[k][7:0]));
            read_reg(int'(VEC[k][44:40]), v);
            chk(v == VEC[k][39:8], $sformatf("R3/R4/R5/R6/R7/R8/R10 vector %0d", k), v, VEC[k][39:8]);
        end

        // R2: a stray valid pulse during execution carries a word that must be ignored.
        run_inst(enc_add(12, 2, 1), 2, 5, enc_addi(1, 0, 0), lat);
        read_reg(12, v);
        chk(v == 32'd3917, "R2 sum with stray pulse", v, 32'd3917);
        read_reg(1, v);
        chk(v == 32'd1946, "R2 stray word ignored", v, 32'd1946);
        chk(lat == 34, "R9 latency with stray pulse", 32'(lat), 32'd34);

        // R11: observation port follows the select without a clock edge.
        read_reg(2, v);
        chk(v == 32'd1971, "R11 read port x2", v, 32'd1971);
        read_reg(9, v);
        chk(v == 32'hFFFF_F800, "R11 read port x9", v, 32'hFFFF_F800);
        read_reg(0, v);
        chk(v == 32'd0, "R7 x0 reads zero", v, 32'd0);

        // R1: reset in the middle of operation restores the start state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ibus_addr_vld && ibus_addr == 0, "R1 restart address", ibus_addr, 32'd0);
        read_reg(4, v);
        chk(v == 32'd0, "R1 registers cleared", v, 32'd0);
        exp_pc = '0;
        run_inst(enc_addi(4, 4, 7), 0, 0, '0, lat);
        read_reg(4, v);
        chk(v == 32'd7, "R3 after restart", v, 32'd7);
        run_inst(enc_addi(13, 4, -8), 1, 0, '0, lat);
        read_reg(13, v);
        chk(v == 32'hFFFF_FFFF, "R6 negative result", v, 32'hFFFF_FFFF);
        chk(ibus_addr == 32'd8, "R1 address after two instructions", ibus_addr, 32'd8);

        finish_run();
    end
endmodule